// File: doc/BRIEF.md
# Prescaled PWM Generator

This block drives a single pulse-width-modulated output. Its period is not one programmable terminal count. It is a product of four factors: a selectable time base, a small pre-divider (2, 3, 5 or 6), a power-of-two stage 2^m with m from 0 to 7, and a resolution counter that runs over either 2^6 or 2^9 steps. The time base is chosen from three clock-enable strobes supplied by the surrounding chip: a slow tick near 1 kHz, a middle tick near 32 kHz and a fast tick near 19.2 MHz. The block runs on the system clock and advances only on the selected strobe.

Configuration arrives on plain register inputs. A bypass input selects the duty value. It takes either the directly programmed value or a value driven by an external ramp sequencer. The block marks the last clock of every period on `periodMark`, so such a sequencer can present its next value in time. Every configuration field and the duty value are sampled into an active copy only at a period boundary, which keeps the output free of glitches. While the generator is disabled, that copy follows the inputs directly.

Top module: `prescaledPwm`

## Requirements
- R1: When running, the spacing between successive `periodMark` pulses in system clocks equals (source tick spacing) x (pre-divide) x 2^m x 2^N, where N is 9 when `size9`=1 and 6 when `size9`=0.
- R2: `clkSel` encodes 0 = no time base, 1 = `tickSlow`, 2 = `tickMid`, 3 = `tickFast`. With 0, `pwmOut` and `periodMark` stay low even if `pwmEn`=1. Strobes that are not selected have no effect on the period.
- R3: `divCode` maps 0 to a pre-divide of 2, 1 to 3, 2 to 5 and 3 to 6.
- R4: `expM` (3 bits, 0 to 7) multiplies the prescale interval by 2^expM.
- R5: In 6-bit mode (`size9`=0) only bits [5:0] of the duty value are used and the resolution counter never exceeds 63. In 9-bit mode it never exceeds 511.
- R6: `pwmOut` is high while the resolution count is below the effective duty value. Per period, the high time is duty x (prescale interval). A duty of 0 gives a constant low output, and 2^N-1 gives high in all but the final step.
- R7: `pwmOut` can be high only when both `pwmEn` and `outEn` are 1. With `outEn`=0 and `pwmEn`=1, the counters keep running and `periodMark` keeps pulsing.
- R8: `useDirect`=1 selects `dutyReg` as the duty value. `useDirect`=0 selects `seqDuty`.
- R9: A change of duty or period configuration during a running period takes effect only after the next `periodMark`. `periodMark` is high during the last system clock of each period.
- R10: When `pwmEn`=0 all counters clear, `pwmOut` is low in the same cycle, and the configuration inputs are taken directly. After re-enabling, the first period starts from count 0 and lasts exactly one full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickSlow | input | 1 | Slow time-base strobe (1 kHz class) |
| tickMid | input | 1 | Middle time-base strobe (32 kHz class) |
| tickFast | input | 1 | Fast time-base strobe (19.2 MHz class) |
| clkSel | input | 2 | Time-base select: 0 none, 1 slow, 2 mid, 3 fast |
| divCode | input | 2 | Pre-divide code: 0→2, 1→3, 2→5, 3→6 |
| expM | input | 3 | Power-of-two prescale exponent |
| size9 | input | 1 | 1 = 9-bit resolution, 0 = 6-bit |
| dutyReg | input | 9 | Directly programmed duty value |
| seqDuty | input | 9 | Duty value from an external sequencer |
| useDirect | input | 1 | 1 selects dutyReg, 0 selects seqDuty |
| pwmEn | input | 1 | Generator enable; low clears all counters |
| outEn | input | 1 | Output enable |
| pwmOut | output | 1 | PWM output |
| periodMark | output | 1 | High in the last clock of each period |

## Verification
The checker watches the following every cycle:
- the output is low whenever either enable is low, the time base is off or the effective duty is zero;
- the resolution counter stays within its mode's range and returns to zero after each mark;
- the active duty holds steady between marks.

Only the bench scenarios can show the arithmetic. These cover:
- period length as the product of tick spacing, pre-divide, 2^m and 2^N;
- high time as a function of duty, including the ignored upper bits in 6-bit mode;
- the choice between the direct and sequencer duty;
- a mid-period duty change landing exactly one period later.

// File: rtl/prescaledPwmPkg.sv
package prescaledPwmPkg;

  localparam int SEL_W      = 2;
  localparam int CODE_W     = 2;
  localparam int EXP_W      = 3;
  localparam int DUTY_W     = 9;
  localparam int SMALL_W    = 6;
  localparam int DIV_W      = 3;

  typedef struct packed {
    logic [SEL_W-1:0]  clkSel;
    logic [CODE_W-1:0] divCode;
    logic [EXP_W-1:0]  expM;
    logic              size9;
    logic [DUTY_W-1:0] duty;
  } pwmCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic advance;
  } dpStrobe_t;

  function automatic logic [DIV_W-1:0] divFromCode(input logic [CODE_W-1:0] code);
    case (code)
      2'd0:    return DIV_W'(2);
      2'd1:    return DIV_W'(3);
      2'd2:    return DIV_W'(5);
      default: return DIV_W'(6);
    endcase
  endfunction

endpackage

// File: rtl/pwmCtrl.sv
module pwmCtrl
  import prescaledPwmPkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [NUM_SRC-1:0] srcTicks,
  input  pwmCfg_t      cfgIn,
  input  logic         pwmEn,
  input  logic         periodMark,
  output pwmCfg_t      cfgAct,
  output logic         running,
  output dpStrobe_t    strobe
);

  localparam int M_MAX  = (1 << EXP_W) - 1;
  localparam int EXPC_W = (M_MAX < 1) ? 1 : M_MAX;

  logic              srcTick;
  logic [NUM_SRC:0]  tickTable;
  logic [DIV_W-1:0]  preCnt;
  logic [DIV_W-1:0]  divEnd;
  logic [EXPC_W-1:0] expCnt;
  logic [EXPC_W-1:0] expEnd;
  logic [EXPC_W:0]   expSpan;
  logic              preWrap;
  logic              advance;
  logic              loadCfg;

  // select entry 0 is "no time base"
  assign tickTable[0] = 1'b0;
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign tickTable[s+1] = srcTicks[s];
  end

  always_comb begin
    srcTick = 1'b0;
    if (int'(cfgAct.clkSel) <= NUM_SRC) srcTick = tickTable[cfgAct.clkSel];
  end

  assign running = pwmEn && (cfgAct.clkSel != '0);
  assign loadCfg = !running || periodMark;

  always_ff @(posedge clk) begin
    if (!rstN)        cfgAct <= '0;
    else if (loadCfg) cfgAct <= cfgIn;
  end

  assign divEnd  = divFromCode(cfgAct.divCode) - DIV_W'(1);
  assign expSpan = (EXPC_W+1)'(1) << cfgAct.expM;
  assign expEnd  = EXPC_W'(expSpan - (EXPC_W+1)'(1));
  assign preWrap = srcTick && (preCnt == divEnd);
  assign advance = running && preWrap && (expCnt == expEnd);

  always_ff @(posedge clk) begin
    if (!rstN || !running) begin
      preCnt <= '0;
      expCnt <= '0;
    end else if (srcTick) begin
      if (preCnt == divEnd) begin
        preCnt <= '0;
        expCnt <= (expCnt == expEnd) ? '0 : expCnt + EXPC_W'(1);
      end else begin
        preCnt <= preCnt + DIV_W'(1);
      end
    end
  end

  assign strobe.clear   = !running;
  assign strobe.advance = advance;

endmodule

// File: rtl/pwmDatapath.sv
module pwmDatapath
  import prescaledPwmPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              size9,
  input  logic [DUTY_W-1:0] duty,
  input  logic              outEn,
  output logic [DUTY_W-1:0] resCnt,
  output logic [DUTY_W-1:0] dutyEff,
  output logic              periodMark,
  output logic              pwmOut
);

  localparam logic [DUTY_W-1:0] LARGE_TOP = DUTY_W'((1 << DUTY_W) - 1);
  localparam logic [DUTY_W-1:0] SMALL_TOP = DUTY_W'((1 << SMALL_W) - 1);

  logic [DUTY_W-1:0] topVal;
  logic              atTop;

  // upper duty bits only count in the wide mode
  for (genvar b = 0; b < DUTY_W; b++) begin : g_mask
    if (b < SMALL_W) begin : g_low
      assign dutyEff[b] = duty[b];
    end else begin : g_high
      assign dutyEff[b] = duty[b] & size9;
    end
  end

  assign topVal     = size9 ? LARGE_TOP : SMALL_TOP;
  assign atTop      = (resCnt == topVal);
  assign periodMark = strobe.advance && atTop;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) resCnt <= '0;
    else if (strobe.advance)   resCnt <= atTop ? '0 : resCnt + DUTY_W'(1);
  end

  assign pwmOut = outEn && !strobe.clear && (resCnt < dutyEff);

endmodule

// File: rtl/prescaledPwm.sv
module prescaledPwm
  import prescaledPwmPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSlow,
  input  logic              tickMid,
  input  logic              tickFast,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic [CODE_W-1:0] divCode,
  input  logic [EXP_W-1:0]  expM,
  input  logic              size9,
  input  logic [DUTY_W-1:0] dutyReg,
  input  logic [DUTY_W-1:0] seqDuty,
  input  logic              useDirect,
  input  logic              pwmEn,
  input  logic              outEn,
  output logic              pwmOut,
  output logic              periodMark
);

  pwmCfg_t           cfgIn;
  pwmCfg_t           cfgAct;
  dpStrobe_t         strobe;
  logic              running;
  logic [DUTY_W-1:0] resCnt;
  logic [DUTY_W-1:0] dutyEff;

  always_comb begin
    cfgIn.clkSel  = clkSel;
    cfgIn.divCode = divCode;
    cfgIn.expM    = expM;
    cfgIn.size9   = size9;
    cfgIn.duty    = useDirect ? dutyReg : seqDuty;
  end

  pwmCtrl #(.NUM_SRC(3)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .srcTicks   ({tickFast, tickMid, tickSlow}),
    .cfgIn      (cfgIn),
    .pwmEn      (pwmEn),
    .periodMark (periodMark),
    .cfgAct     (cfgAct),
    .running    (running),
    .strobe     (strobe)
  );

  pwmDatapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .size9      (cfgAct.size9),
    .duty       (cfgAct.duty),
    .outEn      (outEn),
    .resCnt     (resCnt),
    .dutyEff    (dutyEff),
    .periodMark (periodMark),
    .pwmOut     (pwmOut)
  );

endmodule

// File: rtl/prescaledPwmChecker.sv
module prescaledPwmChecker (
  input logic       clk,
  input logic       rstN,
  input logic       pwmEn,
  input logic       outEn,
  input logic       pwmOut,
  input logic       periodMark,
  input logic       running,
  input logic       size9Act,
  input logic [8:0] resCnt,
  input logic [8:0] dutyEff,
  input logic [8:0] dutyAct
);

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !pwmEn |-> !pwmOut);

  assert_outen_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !pwmOut);

  assert_no_base_R2: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!pwmOut && !periodMark));

  assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dutyEff == 9'd0) |-> !pwmOut);

  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    resCnt <= (size9Act ? 9'd511 : 9'd63));

  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (periodMark && pwmEn) |=> (resCnt == 9'd0));

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (running && !periodMark && pwmEn) |=> (!pwmEn || $stable(dutyAct)));

endmodule

bind prescaledPwm prescaledPwmChecker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .pwmEn      (pwmEn),
  .outEn      (outEn),
  .pwmOut     (pwmOut),
  .periodMark (periodMark),
  .running    (running),
  .size9Act   (cfgAct.size9),
  .resCnt     (resCnt),
  .dutyEff    (dutyEff),
  .dutyAct    (cfgAct.duty)
);

// File: tb/prescaledPwm_test.sv
module prescaledPwm_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickSlow = 1'b0;
  logic       tickMid = 1'b0;
  logic       tickFast = 1'b1;
  logic [1:0] clkSel = 2'd3;
  logic [1:0] divCode = 2'd0;
  logic [2:0] expM = 3'd0;
  logic       size9 = 1'b0;
  logic [8:0] dutyReg = 9'd0;
  logic [8:0] seqDuty = 9'd0;
  logic       useDirect = 1'b1;
  logic       pwmEn = 1'b0;
  logic       outEn = 1'b1;
  logic       pwmOut;
  logic       periodMark;

  int vectors = 0;
  int errors = 0;
  int tickCnt = 0;
  int cycles = 0;
  bit timedOut = 1'b0;

  prescaledPwm uut (
    .clk(clk), .rstN(rstN), .tickSlow(tickSlow), .tickMid(tickMid),
    .tickFast(tickFast), .clkSel(clkSel), .divCode(divCode), .expM(expM),
    .size9(size9), .dutyReg(dutyReg), .seqDuty(seqDuty),
    .useDirect(useDirect), .pwmEn(pwmEn), .outEn(outEn),
    .pwmOut(pwmOut), .periodMark(periodMark)
  );

  always #5 clk = ~clk;

  // bench-side strobes: mid every 2 clocks, slow every 8 clocks
  always @(negedge clk) begin
    tickCnt  <= tickCnt + 1;
    tickMid  <= ((tickCnt + 1) % 2) == 0;
    tickSlow <= ((tickCnt + 1) % 8) == 0;
    cycles   <= cycles + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int divOf(input int code);
    case (code)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 6;
    endcase
  endfunction

  // sync to a mark, then measure one full period; optionally change dutyReg mid-period
  task automatic measure(output int len, output int hi, input int chgAt, input int newDuty);
    int guard;
    guard = 0;
    len = 0;
    hi = 0;
    while (guard < 40000) begin
      @(negedge clk); #1;
      guard++;
      if (periodMark) break;
    end
    while (guard < 40000) begin
      @(negedge clk); #1;
      guard++;
      len++;
      if (pwmOut) hi++;
      if (len == chgAt) dutyReg = 9'(newDuty);
      if (periodMark) break;
    end
    if (guard >= 40000) begin
      timedOut = 1'b1;
      len = -1;
    end
  endtask

  task automatic restart(input int sel, input int dc, input int m, input bit s9, input int d);
    @(negedge clk);
    pwmEn   = 1'b0;
    clkSel  = 2'(sel);
    divCode = 2'(dc);
    expM    = 3'(m);
    size9   = s9;
    dutyReg = 9'(d);
    @(negedge clk);
    pwmEn = 1'b1;
  endtask

  initial begin : watchdog
    wait (cycles > 190000);
    timedOut = 1'b1;
    errors++;
    vectors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stim
    int len, hi, p, cnt, mk;
    int duties[5];
    duties = '{0, 1, 33, 63, 70};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R10 reset out", int'(pwmOut), 0);
    check("R10 reset mark", int'(periodMark), 0);

    // R3 R6 R5 R1: 6-bit sweep over pre-divide, exponent 0/1 and duties
    for (int dc = 0; dc < 4; dc++) begin
      for (int m = 0; m < 2; m++) begin
        for (int k = 0; k < 5; k++) begin
          restart(3, dc, m, 1'b0, duties[k]);
          measure(len, hi, -1, 0);
          p = divOf(dc) * (1 << m);
          check("R3 R1 period", len, p * 64);
          check("R6 R5 high time", hi, (duties[k] % 64) * p);
        end
      end
    end

    // R4: exponent sweep
    for (int m = 0; m < 6; m++) begin
      restart(3, 0, m, 1'b0, 1);
      measure(len, hi, -1, 0);
      check("R4 exponent period", len, 2 * (1 << m) * 64);
      check("R4 exponent high", hi, 2 * (1 << m));
    end
    restart(3, 0, 7, 1'b0, 63);
    measure(len, hi, -1, 0);
    check("R4 m=7 period", len, 2 * 128 * 64);
    check("R6 max duty high", hi, 2 * 128 * 63);

    // R5 R6: 9-bit mode
    begin
      int wide[4];
      wide = '{0, 1, 256, 511};
      for (int k = 0; k < 4; k++) begin
        restart(3, 0, 0, 1'b1, wide[k]);
        measure(len, hi, -1, 0);
        check("R5 9-bit period", len, 1024);
        check("R6 9-bit high", hi, wide[k] * 2);
      end
    end

    // R2: source selection, other strobes ignored (fast held high throughout)
    restart(2, 0, 0, 1'b0, 10);
    measure(len, hi, -1, 0);
    check("R2 mid source period", len, 2 * 2 * 64);
    check("R2 mid source high", hi, 2 * 2 * 10);
    restart(1, 0, 0, 1'b0, 10);
    measure(len, hi, -1, 0);
    check("R2 slow source period", len, 8 * 2 * 64);
    check("R2 slow source high", hi, 8 * 2 * 10);

    // R2: no time base
    restart(0, 0, 0, 1'b0, 40);
    cnt = 0; mk = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (pwmOut) cnt++;
      if (periodMark) mk++;
    end
    check("R2 sel0 high", cnt, 0);
    check("R2 sel0 marks", mk, 0);

    // R7: output enable low keeps counting
    outEn = 1'b0;
    restart(3, 0, 0, 1'b0, 32);
    measure(len, hi, -1, 0);
    check("R7 outEn low period", len, 128);
    check("R7 outEn low high", hi, 0);
    outEn = 1'b1;

    // R8: duty source select
    seqDuty = 9'd16;
    useDirect = 1'b0;
    restart(3, 0, 0, 1'b0, 48);
    measure(len, hi, -1, 0);
    check("R8 sequencer duty", hi, 32);
    useDirect = 1'b1;
    restart(3, 0, 0, 1'b0, 48);
    measure(len, hi, -1, 0);
    check("R8 direct duty", hi, 96);

    // R9: mid-period change waits for boundary
    restart(3, 0, 0, 1'b0, 10);
    measure(len, hi, 5, 40);
    check("R9 old duty kept", hi, 20);
    check("R9 period length", len, 128);
    measure(len, hi, -1, 0);
    check("R9 new duty next period", hi, 80);

    // R10: disable clears, restart from zero
    restart(3, 0, 0, 1'b0, 64);
    repeat (37) @(negedge clk);
    pwmEn = 1'b0;
    #1;
    check("R10 disable out low", int'(pwmOut), 0);
    @(negedge clk); #1;
    check("R10 disabled out low", int'(pwmOut), 0);
    pwmEn = 1'b1;
    #1;
    cnt = 1;
    while (!periodMark && cnt < 1000) begin
      @(negedge clk); #1;
      cnt++;
    end
    check("R10 first period after enable", cnt, 128);

    if (timedOut) begin
      errors++;
      vectors++;
      $display("FAIL timeout: actual %0d expected %0d", 1, 0);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule